// File: doc/BRIEF.md
# Consumer Clock Source Selector

This block feeds six consumer clock slots from a shared set of tick sources. Each slot picks one of seven sources: an auxiliary PLL tick or one of six frequency generator ticks. It then divides the chosen tick stream by a small factor and drives a gated output tick and a square wave. All sources arrive as single-cycle strobes in the system clock domain. A slot with no source selected is switched off and its outputs stay low.

All six slots are set up through one 32-bit control word that software writes with a per-bit mask and can read back. Each slot owns a 5-bit field of that word. The field's upper three bits choose the source and its lower two bits index a four-entry divide table. The table is not in ascending order, and a build parameter chooses between two versions. In the legacy version, codes 0 and 2 both mean divide-by-1. The enhanced version turns code 2 into divide-by-3. A second parameter marks slots that are absent in a given configuration. Those slots still store and return their field, but they never drive an output.

Top module: `ccs_top`

## Requirements
- R1: After reset the control word reads as zero, every slot is disabled, and every output tick and square wave is low.
- R2: A write changes only the control bits whose `wr_mask` bit is 1. `rd_data` returns the stored word at once. Bits 31:30 are not stored and read as 0.
- R3: Slot i is controlled by bits 5i+4 to 5i. Field bits 4:2 pick the source: 1 is the auxiliary tick, and 2 through 7 are generator ticks 0 through 5.
- R4: A slot whose source bits are 000 keeps its output tick and square wave low, whatever its divide code.
- R5: Field bits 1:0 select the divisor. Code 0 gives 1, code 1 gives 4 and code 3 gives 2. Code 2 gives 3 when ENHANCED is 1 and gives 1 when ENHANCED is 0.
- R6: With divisor 1, the slot's output tick equals its selected source tick in the same cycle.
- R7: With divisor d greater than 1, the output tick fires in the same cycle as the d-th, 2d-th and later source ticks, counted from enable or restart.
- R8: A write that changes a slot's field restarts its count and clears its square wave. The next source tick counts as the first. A source tick in the write cycle itself is still handled under the old field.
- R9: The square wave inverts at the clock edge that ends each output-tick cycle and holds otherwise.
- R10: A slot whose SLOT_USED bit is 0 stores and reads back its field but keeps both of its outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write enable |
| rd_data | output | 32 | Current control word |
| aux_tick | input | 1 | Auxiliary PLL tick strobe |
| gen_tick | input | 6 | Frequency generator tick strobes |
| out_tick | output | 6 | Per-slot divided output tick |
| out_wave | output | 6 | Per-slot square wave |

## Verification
A write that reconfigures a slot can land in the same cycle as a source tick that completes the slot's current divide period. In that cycle the old setting must still produce its output tick, and the count and square wave must then restart under the new field. The bench provokes this case directly by writing a new divisor while an aux tick is present on the final count. It also hits the case many times in a random soak that combines masked writes with random tick patterns. Both cases are judged cycle by cycle against a behavioural model.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int unsigned FIELD_W = 5;
  localparam int unsigned SRC_W   = 3;
  localparam int unsigned CODE_W  = 2;
  localparam int unsigned CNT_W   = 2;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [CODE_W-1:0] code;
  } slot_cfg_t;

  // Divisor minus one for a divide code; code 2 depends on the table variant.
  function automatic logic [CNT_W-1:0] last_count(input logic [CODE_W-1:0] code,
                                                  input bit enhanced);
    logic [CNT_W-1:0] r;
    case (code)
      2'd0:    r = CNT_W'(0);
      2'd1:    r = CNT_W'(3);
      2'd2:    r = enhanced ? CNT_W'(2) : CNT_W'(0);
      default: r = CNT_W'(1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ccs_cfg_regs.sv
module ccs_cfg_regs
  import ccs_pkg::*;
#(
  parameter int unsigned SLOTS = 6,
  parameter int unsigned REG_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [REG_W-1:0]            wr_data,
  input  logic [REG_W-1:0]            wr_mask,
  output slot_cfg_t [SLOTS-1:0]       cfg,
  output logic [SLOTS-1:0]            restart,
  output logic [REG_W-1:0]            rd_data
);
  localparam int unsigned STORE_W = SLOTS * FIELD_W;

  logic [STORE_W-1:0] store_q;
  logic [STORE_W-1:0] store_d;

  assign store_d = wr_en
    ? ((store_q & ~wr_mask[STORE_W-1:0]) | (wr_data[STORE_W-1:0] & wr_mask[STORE_W-1:0]))
    : store_q;

  always_ff @(posedge clk) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= store_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_field
    assign cfg[g]     = store_q[g*FIELD_W +: FIELD_W];
    assign restart[g] = store_d[g*FIELD_W +: FIELD_W] != store_q[g*FIELD_W +: FIELD_W];
  end

  assign rd_data = REG_W'(store_q);
endmodule

// File: rtl/ccs_src_mux.sv
module ccs_src_mux
  import ccs_pkg::*;
#(
  parameter int unsigned GENS = 6
) (
  input  logic [SRC_W-1:0] src,
  input  logic             aux_tick,
  input  logic [GENS-1:0]  gen_tick,
  output logic             src_on,
  output logic             tick
);
  assign src_on = src != '0;

  always_comb begin
    tick = 1'b0;
    if (src == SRC_W'(1)) tick = aux_tick;
    for (int j = 0; j < GENS; j++) begin
      if (src == SRC_W'(j + 2)) tick = gen_tick[j];
    end
  end
endmodule

// File: rtl/ccs_slot_div.sv
module ccs_slot_div
  import ccs_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  input  logic              src_tick,
  output logic              out_tick,
  output logic              out_wave
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             wave_q;

  assign last     = last_count(code, ENHANCED);
  assign out_tick = active & src_tick & (cnt_q == last);
  assign out_wave = wave_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (!active || restart) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (src_tick) begin
      cnt_q  <= out_tick ? '0 : cnt_q + CNT_W'(1);
      wave_q <= wave_q ^ out_tick;
    end
  end
endmodule

// File: rtl/ccs_top.sv
module ccs_top
  import ccs_pkg::*;
#(
  parameter int unsigned     SLOTS     = 6,
  parameter int unsigned     GENS      = 6,
  parameter int unsigned     REG_W     = 32,
  parameter bit              ENHANCED  = 1'b1,
  parameter logic [SLOTS-1:0] SLOT_USED = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_mask,
  output logic [REG_W-1:0] rd_data,
  input  logic             aux_tick,
  input  logic [GENS-1:0]  gen_tick,
  output logic [SLOTS-1:0] out_tick,
  output logic [SLOTS-1:0] out_wave
);
  slot_cfg_t [SLOTS-1:0] cfg;
  logic [SLOTS-1:0]      slot_en;
  logic [SLOTS-1:0]      slot_sel_tick;
  logic [SLOTS-1:0]      slot_restart;

  ccs_cfg_regs #(.SLOTS(SLOTS), .REG_W(REG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .cfg     (cfg),
    .restart (slot_restart),
    .rd_data (rd_data)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    ccs_src_mux #(.GENS(GENS)) u_mux (
      .src      (cfg[g].src),
      .aux_tick (aux_tick),
      .gen_tick (gen_tick),
      .src_on   (slot_en[g]),
      .tick     (slot_sel_tick[g])
    );

    if (SLOT_USED[g]) begin : g_used
      ccs_slot_div #(.ENHANCED(ENHANCED)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (slot_en[g]),
        .restart  (slot_restart[g]),
        .code     (cfg[g].code),
        .src_tick (slot_sel_tick[g]),
        .out_tick (out_tick[g]),
        .out_wave (out_wave[g])
      );
    end else begin : g_unused
      assign out_tick[g] = 1'b0;
      assign out_wave[g] = 1'b0;
    end
  end
endmodule

// File: rtl/ccs_checker.sv
module ccs_checker #(
  parameter int unsigned      SLOTS     = 6,
  parameter int unsigned      REG_W     = 32,
  parameter logic [SLOTS-1:0] SLOT_USED = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_mask,
  input logic [REG_W-1:0] rd_data,
  input logic [SLOTS-1:0] out_tick,
  input logic [SLOTS-1:0] out_wave,
  input logic [SLOTS-1:0] slot_en,
  input logic [SLOTS-1:0] slot_sel_tick,
  input logic [SLOTS-1:0] slot_restart
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_data == '0 && out_wave == '0));

  assert_mask_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data & ~$past(wr_mask)) == ($past(rd_data) & ~$past(wr_mask))));

  for (genvar g = 0; g < SLOTS; g++) begin : g_chk
    assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_en[g] |-> (!out_tick[g] && !out_wave[g]));

    assert_tick_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick[g] |-> slot_sel_tick[g]);

    assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_restart[g] |=> !out_wave[g]);

    assert_wave_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_tick[g] && !slot_restart[g]) |=> (out_wave[g] != $past(out_wave[g])));

    assert_wave_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_tick[g] && !slot_restart[g]) |=> $stable(out_wave[g]));

    if (!SLOT_USED[g]) begin : g_unused
      assert_unused_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en[g] |-> (!out_tick[g] && !out_wave[g]));
    end
  end
endmodule

bind ccs_top ccs_checker #(
  .SLOTS(SLOTS), .REG_W(REG_W), .SLOT_USED(SLOT_USED)
) u_chk (.*);

// File: tb/sim_ccs_top.sv
`timescale 1ns/1ps
module sim_ccs_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, wr_en, aux_tick;
  logic [31:0] wr_data, wr_mask;
  logic [5:0]  gen_tick;
  logic [31:0] rd0, rd1;
  logic [5:0]  tk0, tk1, wv0, wv1;

  // drive values, applied to the DUTs at the falling edge
  bit          d_rst = 1'b0, d_we = 1'b0, d_aux = 1'b0;
  logic [31:0] d_data = '0, d_mask = '0;
  logic [5:0]  d_gen = '0;

  ccs_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
              .rd_data(rd0), .aux_tick(aux_tick), .gen_tick(gen_tick), .out_tick(tk0), .out_wave(wv0));
  ccs_top #(.ENHANCED(1'b0), .SLOT_USED(6'b101111)) u1 (
              .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
              .rd_data(rd1), .aux_tick(aux_tick), .gen_tick(gen_tick), .out_tick(tk1), .out_wave(wv1));

  // reference model state
  logic [29:0] mreg [2];
  int          mcnt [2][6];
  bit          mwave[2][6];
  int checks = 0, fails = 0;
  string tag = "R1";
  int obs0 = 0, obs1 = 0, obs_u0s4 = 0, bad_s1 = 0, bad_u1s4 = 0;
  logic [31:0] cap_rd0, cap_rd1;
  logic [5:0]  cap_tk0, cap_wv0;

  function automatic int divisor(logic [1:0] code, bit enh);
    if (code == 2'd1) return 4;
    if (code == 2'd3) return 2;
    if (code == 2'd2 && enh) return 3;
    return 1;
  endfunction

  function automatic bit src_hit(logic [2:0] s);
    if (s == 3'd0) return 1'b0;
    if (s == 3'd1) return d_aux;
    return d_gen[s - 3'd2];
  endfunction

  function automatic bit slot_live(int k, int i);
    logic [4:0] f = mreg[k][5*i +: 5];
    return (k == 0 || i != 4) && f[4:2] != 3'd0;
  endfunction

  function automatic bit exp_tick(int k, int i);
    logic [4:0] f = mreg[k][5*i +: 5];
    return slot_live(k, i) && src_hit(f[4:2]) && (mcnt[k][i] == divisor(f[1:0], k == 0) - 1);
  endfunction

  task automatic expect_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int k = 0; k < 2; k++) begin
      logic [31:0] rd, erd;
      logic [5:0]  tk, wv, etk, ewv;
      rd = (k == 0) ? rd0 : rd1;
      tk = (k == 0) ? tk0 : tk1;
      wv = (k == 0) ? wv0 : wv1;
      erd = {2'b00, mreg[k]};
      for (int i = 0; i < 6; i++) begin
        etk[i] = exp_tick(k, i);
        ewv[i] = mwave[k][i];
      end
      checks++;
      if (rd !== erd || tk !== etk || wv !== ewv) begin
        fails++;
        $display("FAIL %s dut%0d: rd=%h tick=%b wave=%b expected rd=%h tick=%b wave=%b",
                 tag, k, rd, tk, wv, erd, etk, ewv);
      end
    end
    obs0 += int'(tk0[0]);
    obs1 += int'(tk1[0]);
    obs_u0s4 += int'(tk0[4]);
    bad_s1 += int'(tk0[1] | wv0[1]);
    bad_u1s4 += int'(tk1[4] | wv1[4]);
    cap_rd0 = rd0; cap_rd1 = rd1; cap_tk0 = tk0; cap_wv0 = wv0;
  endtask

  task automatic model_edge();
    for (int k = 0; k < 2; k++) begin
      logic [29:0] nreg;
      nreg = (mreg[k] & ~d_mask[29:0]) | (d_data[29:0] & d_mask[29:0]);
      for (int i = 0; i < 6; i++) begin
        logic [4:0] f = mreg[k][5*i +: 5];
        if (!d_rst || !slot_live(k, i)) begin
          mcnt[k][i] = 0; mwave[k][i] = 1'b0;
        end else if (src_hit(f[4:2])) begin
          if (exp_tick(k, i)) begin
            mcnt[k][i] = 0; mwave[k][i] = ~mwave[k][i];
          end else mcnt[k][i]++;
        end
        if (d_rst && d_we && nreg[5*i +: 5] != f) begin
          mcnt[k][i] = 0; mwave[k][i] = 1'b0;
        end
      end
      if (!d_rst) mreg[k] = '0;
      else if (d_we) mreg[k] = nreg;
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    rst_n = d_rst; wr_en = d_we; wr_data = d_data; wr_mask = d_mask;
    aux_tick = d_aux; gen_tick = d_gen;
    #1;
    if (d_rst) compare();
    @(posedge clk);
    model_edge();
  endtask

  task automatic wr(logic [31:0] data, logic [31:0] mask);
    d_we = 1'b1; d_data = data; d_mask = mask;
    cycle();
    d_we = 1'b0;
  endtask

  task automatic pulse_aux(int n, int gap);
    for (int p = 0; p < n; p++) begin
      d_aux = 1'b1; cycle();
      d_aux = 1'b0;
      for (int q = 0; q < gap; q++) cycle();
    end
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      mreg[k] = '0;
      for (int i = 0; i < 6; i++) begin mcnt[k][i] = 0; mwave[k][i] = 1'b0; end
    end
    for (int c = 0; c < 4; c++) cycle();
    d_rst = 1'b1;
    cycle();
    // R1: reset state
    expect_eq("R1", "control word", int'(cap_rd0), 0);
    expect_eq("R1", "ticks", int'(cap_tk0), 0);
    expect_eq("R1", "waves", int'(cap_wv0), 0);

    // R2: masked writes
    tag = "R2";
    wr(32'hFFFF_FFFF, 32'h0000_03E0); cycle();
    expect_eq("R2", "masked set", int'(cap_rd0), 32'h3E0);
    wr(32'h0, 32'h0000_0020); cycle();
    expect_eq("R2", "masked clear", int'(cap_rd0), 32'h3C0);
    wr(32'hFFFF_FFFF, 32'hC000_0000); cycle();
    expect_eq("R2", "top bits not stored", int'(cap_rd1), 32'h3C0);
    wr(32'h0, 32'hFFFF_FFFF);

    // R6: divide by 1 follows the source tick
    tag = "R6";
    wr(32'h4, 32'h1F);
    obs0 = 0; obs1 = 0;
    pulse_aux(5, 1);
    expect_eq("R6", "div1 ticks u0", obs0, 5);
    expect_eq("R6", "div1 ticks u1", obs1, 5);

    // R7: divide by 4
    tag = "R7";
    wr(32'h5, 32'h1F);
    obs0 = 0; obs1 = 0;
    pulse_aux(8, 2);
    expect_eq("R7", "div4 ticks", obs0, 2);

    // R5: code 2 differs between tables, code 3 halves
    tag = "R5";
    wr(32'h6, 32'h1F);
    obs0 = 0; obs1 = 0;
    pulse_aux(9, 1);
    expect_eq("R5", "code2 enhanced div3", obs0, 3);
    expect_eq("R5", "code2 legacy div1", obs1, 9);
    wr(32'h7, 32'h1F);
    obs0 = 0; obs1 = 0;
    pulse_aux(6, 0);
    cycle();
    expect_eq("R5", "code3 div2", obs0, 3);
    // R9: three output ticks leave the wave high
    expect_eq("R9", "wave after 3 toggles", int'(cap_wv0[0]), 1);

    // R3: field placement and generator mapping
    tag = "R3";
    wr(32'h000E_0000, 32'h000F_8000);  // slot3 <- generator 5, div1
    wr(32'h0000_2000, 32'h0000_7C00);  // slot2 <- generator 0, div1
    d_gen = 6'b100000; cycle(); d_gen = '0;
    expect_eq("R3", "gen5 reaches slot3 only", int'(cap_tk0), 6'b001000);
    d_gen = 6'b000001; cycle(); d_gen = '0;
    expect_eq("R3", "gen0 reaches slot2 only", int'(cap_tk0), 6'b000100);
    d_gen = 6'b011110; cycle(); d_gen = '0;
    expect_eq("R3", "other gens reach nothing", int'(cap_tk0), 0);

    // R4: zero source with non-zero divide code stays quiet
    tag = "R4";
    wr(32'h0000_0060, 32'h0000_03E0);
    bad_s1 = 0;
    for (int c = 0; c < 60; c++) begin
      d_aux = 1'($urandom); d_gen = 6'($urandom); cycle();
    end
    d_aux = 1'b0; d_gen = '0;
    expect_eq("R4", "disabled slot1 activity", bad_s1, 0);

    // R8: restart on reconfiguration, including a tick in the write cycle
    tag = "R8";
    wr(32'h0, 32'hFFFF_FFFF);
    wr(32'h5, 32'h1F);
    pulse_aux(2, 1);
    wr(32'h7, 32'h1F);
    obs0 = 0;
    pulse_aux(1, 1);
    expect_eq("R8", "first tick after restart", obs0, 0);
    pulse_aux(1, 1);
    expect_eq("R8", "second tick after restart", obs0, 1);
    pulse_aux(1, 1);
    obs0 = 0;
    d_aux = 1'b1; wr(32'h5, 32'h1F); d_aux = 1'b0;
    expect_eq("R8", "tick in write cycle uses old divisor", obs0, 1);
    pulse_aux(3, 1);
    expect_eq("R8", "count restarted", obs0, 1);
    pulse_aux(1, 1);
    expect_eq("R8", "fourth tick after restart", obs0, 2);

    // R10: unused slot stored but silent
    tag = "R10";
    wr(32'h0040_0000, 32'h01F0_0000);
    bad_u1s4 = 0; obs_u0s4 = 0;
    pulse_aux(4, 1);
    expect_eq("R10", "unused slot readback", int'(cap_rd1[24:20]), 5'b00100);
    expect_eq("R10", "unused slot activity", bad_u1s4, 0);
    expect_eq("R10", "same slot live on u0", obs_u0s4, 4);

    // R8 soak: random writes colliding with random ticks
    tag = "R8 soak";
    for (int c = 0; c < 3000; c++) begin
      d_aux = 1'($urandom); d_gen = 6'($urandom);
      if ($urandom_range(5) == 0) begin
        d_we = 1'b1; d_data = $urandom; d_mask = $urandom;
      end else d_we = 1'b0;
      cycle();
    end
    d_we = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule